// File: doc/BRIEF.md
# DMA Descriptor Chain Sequencer

This block steps one DMA channel through a linked list of buffer descriptors in memory. Software writes the address of the first descriptor, with its control bits, into a current-descriptor register, picks chaining or direct mode, and pulses a start strobe. In chaining mode the sequencer reads the link word of the current descriptor over a simple request/grant/valid memory read port and captures it in a next-descriptor register. It then asks an external data mover to run the buffer transfer for the current descriptor. When the mover reports completion, the sequencer either promotes the next-descriptor word to current and fetches again, or stops.

The link word is 32 bits. Bit 0 is the end-of-chain flag, bits 2:1 are the transfer type, bit 3 is the end-of-segment interrupt enable, bit 4 is the snoop enable, and bits 31:5 are the address of a 32-byte aligned descriptor. All control bits except end-of-chain act on a transfer only after the word has been moved into the current register. End-of-chain is read straight from the next-descriptor register. When it is set, the other control bits of that word are don't-care and the channel halts once the running transfer ends.

In direct mode no descriptor is fetched. A single transfer runs with the software-written current register, and the channel returns to idle. A sticky interrupt status bit is cleared by writing one to it.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset every register reads 0, `idle_o` is 1, and `irq_o`, `mem_req_o` and `xfer_req_o` are 0.
- R2: `start_i` is accepted only in the idle state. In chaining mode `mem_req_o` is high the cycle after start, and `mem_addr_o` = {CUR[31:5], 5'b0} + LINK_OFS. The request is held with a stable address until `mem_gnt_i`, and it drops the cycle after the grant.
- R3: In chaining mode, the word on `mem_rdata_i` with `mem_rvalid_i` after a grant is loaded into the next-descriptor register (register index 2). Register writes to index 2 are ignored.
- R4: While `xfer_req_o` is high, `xfer_desc_o` = {CUR[31:5], 5'b0}, `xfer_type_o` = CUR[2:1] and `xfer_snoop_o` = CUR[4]. These stay stable until `xfer_done_i`. Type codes: 00 local-to-local, 01 local-to-PCI, 10 PCI-to-local, 11 PCI-to-PCI.
- R5: In chaining mode, a completed transfer whose fetched next word has bit 0 = 0 copies that word into CUR (register index 1) the next cycle. A new fetch then starts the same cycle. The control bits of a fetched word reach the transfer outputs only after this copy.
- R6: A completed transfer whose fetched next word has bit 0 = 1 moves the channel to idle the next cycle. No further fetch follows, and CUR keeps its value, so bits 4:1 of that word have no effect.
- R7: Direct mode is selected by bit 0 of the control register (index 0) being 0; writing 1 selects chaining. Reads of the control register return only that bit. In direct mode start raises `xfer_req_o` the next cycle with no fetch, and completion returns the channel to idle. CUR bit 0 has no effect in either mode.
- R8: In chaining mode, a completed transfer with CUR[3] = 1 sets `irq_o` (status register index 3, bit 0) the next cycle. In direct mode `irq_o` is never set.
- R9: `irq_o` stays set until a write of 1 to bit 0 of status register index 3. If a set and a clear occur in the same cycle, the set wins.
- R10: `idle_o` is high only in the idle and done states, and no request is active then. Writes to the control register and CUR are ignored while `idle_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register index (0 control, 1 current, 2 next, 3 status) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from index |
| start_i | input | 1 | Start strobe |
| mem_req_o | output | 1 | Link word read request |
| mem_addr_o | output | 32 | Link word byte address |
| mem_gnt_i | input | 1 | Read request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data (link word) |
| xfer_req_o | output | 1 | Buffer transfer request to the data mover |
| xfer_desc_o | output | 32 | Address of the descriptor being executed |
| xfer_type_o | output | 2 | Transfer direction code |
| xfer_snoop_o | output | 1 | Snoop enable for the transfer |
| xfer_done_i | input | 1 | Data mover reports the transfer finished |
| irq_o | output | 1 | Sticky end-of-segment interrupt |
| idle_o | output | 1 | Channel idle |

## Verification
Every result comes from one register stage. The fetch request shows the cycle after start and drops the cycle after the grant. The captured link word can be read, and the transfer request rises, the cycle after read-valid. Promotion, the interrupt and the return to idle all appear the cycle after `xfer_done_i`. The bench drives inputs and samples outputs on the falling edge and counts the exact number of falling edges between a stimulus and its check. It sweeps all 32 control-bit patterns of the first descriptor in both modes, with chain lengths and handshake delays derived from the pattern.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int LINK_W    = 32;
  localparam int ALIGN_W   = 5;   // 32-byte descriptor alignment
  localparam int BIT_EOC   = 0;
  localparam int BIT_TYPE  = 1;   // two bits
  localparam int BIT_IRQEN = 3;
  localparam int BIT_SNOOP = 4;
  localparam int REG_AW    = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WAIT_DATA, ST_TRANSFER, ST_DONE
  } seq_state_e;

  typedef enum logic [REG_AW-1:0] {
    RI_CTRL = 2'd0, RI_CUR = 2'd1, RI_NXT = 2'd2, RI_STAT = 2'd3
  } reg_idx_e;

  typedef enum logic [1:0] {
    XT_LOC_LOC = 2'b00, XT_LOC_PCI = 2'b01, XT_PCI_LOC = 2'b10, XT_PCI_PCI = 2'b11
  } xfer_type_e;
endpackage

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
  import dma_chain_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [LINK_W-1:0] wdata_i,
  output logic [LINK_W-1:0] rdata_o,
  input  logic              idle_i,
  input  logic              nxt_load_i,
  input  logic [LINK_W-1:0] nxt_data_i,
  input  logic              promote_i,
  input  logic              irq_set_i,
  output logic              chain_en_o,
  output logic [LINK_W-1:1] cur_o,
  output logic              nxt_eoc_o,
  output logic              irq_o
);
  logic              chain_q;
  logic [LINK_W-1:0] cur_q;
  logic [LINK_W-1:0] nxt_q;
  logic              irq_q;
  logic              sw_cfg_we;
  logic              irq_clr;

  assign sw_cfg_we = we_i && idle_i;
  assign irq_clr   = we_i && (addr_i == RI_STAT) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= 1'b0;
      cur_q   <= '0;
      nxt_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (sw_cfg_we && addr_i == RI_CTRL) chain_q <= wdata_i[0];
      if (promote_i)                          cur_q <= nxt_q;
      else if (sw_cfg_we && addr_i == RI_CUR) cur_q <= wdata_i;
      if (nxt_load_i) nxt_q <= nxt_data_i;
      if (irq_set_i)    irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      RI_CTRL: rdata_o = {{(LINK_W-1){1'b0}}, chain_q};
      RI_CUR:  rdata_o = cur_q;
      RI_NXT:  rdata_o = nxt_q;
      default: rdata_o = {{(LINK_W-1){1'b0}}, irq_q};
    endcase
  end

  assign chain_en_o = chain_q;
  assign cur_o      = cur_q[LINK_W-1:1];
  assign nxt_eoc_o  = nxt_q[BIT_EOC];
  assign irq_o      = irq_q;

  assert_nxt_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nxt_load_i |=> $stable(nxt_q));
  assert_cur_locked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_i && !promote_i) |=> $stable(cur_q));
  assert_irq_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr) |=> irq_q);
  assert_irq_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set_i |=> irq_q);
endmodule

// File: rtl/dma_chain_fsm.sv
module dma_chain_fsm
  import dma_chain_pkg::*;
#(
  parameter int LINK_OFS = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      chain_en_i,
  input  logic [LINK_W-1:ALIGN_W]   cur_addr_i,
  input  logic                      cur_irq_en_i,
  input  logic                      nxt_eoc_i,
  output logic                      mem_req_o,
  output logic [LINK_W-1:0]         mem_addr_o,
  input  logic                      mem_gnt_i,
  input  logic                      mem_rvalid_i,
  output logic                      nxt_load_o,
  output logic                      xfer_req_o,
  input  logic                      xfer_done_i,
  output logic                      promote_o,
  output logic                      irq_set_o,
  output logic                      idle_o
);
  seq_state_e state_q, state_d;
  logic       done_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign done_hit = (state_q == ST_TRANSFER) && xfer_done_i;
  // end-of-chain acts straight from the fetched word, not via promotion
  assign promote_o = done_hit && chain_en_i && !nxt_eoc_i;
  assign irq_set_o = done_hit && chain_en_i && cur_irq_en_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (start_i) state_d = chain_en_i ? ST_FETCH : ST_TRANSFER;
      ST_FETCH:     if (mem_gnt_i) state_d = ST_WAIT_DATA;
      ST_WAIT_DATA: if (mem_rvalid_i) state_d = ST_TRANSFER;
      ST_TRANSFER:  if (xfer_done_i) state_d = promote_o ? ST_FETCH : ST_DONE;
      default:      state_d = ST_IDLE;
    endcase
  end

  assign mem_req_o  = (state_q == ST_FETCH);
  assign mem_addr_o = {cur_addr_i, {ALIGN_W{1'b0}}} + LINK_W'(LINK_OFS);
  assign nxt_load_o = (state_q == ST_WAIT_DATA) && mem_rvalid_i;
  assign xfer_req_o = (state_q == ST_TRANSFER);
  assign idle_o     = (state_q == ST_IDLE) || (state_q == ST_DONE);

  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));
  assert_req_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i) |=> !mem_req_o);
  assert_xfer_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !xfer_done_i) |=> xfer_req_o);
  assert_direct_nofetch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chain_en_i |-> !mem_req_o);
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int LINK_OFS = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        start_i,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_gnt_i,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  output logic        xfer_req_o,
  output logic [31:0] xfer_desc_o,
  output logic [1:0]  xfer_type_o,
  output logic        xfer_snoop_o,
  input  logic        xfer_done_i,
  output logic        irq_o,
  output logic        idle_o
);
  logic              chain_en;
  logic [LINK_W-1:1] cur;
  logic              nxt_eoc;
  logic              nxt_load;
  logic              promote;
  logic              irq_set;

  dma_chain_regs i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .idle_i     (idle_o),
    .nxt_load_i (nxt_load),
    .nxt_data_i (mem_rdata_i),
    .promote_i  (promote),
    .irq_set_i  (irq_set),
    .chain_en_o (chain_en),
    .cur_o      (cur),
    .nxt_eoc_o  (nxt_eoc),
    .irq_o      (irq_o)
  );

  dma_chain_fsm #(.LINK_OFS(LINK_OFS)) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .chain_en_i   (chain_en),
    .cur_addr_i   (cur[LINK_W-1:ALIGN_W]),
    .cur_irq_en_i (cur[BIT_IRQEN]),
    .nxt_eoc_i    (nxt_eoc),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .nxt_load_o   (nxt_load),
    .xfer_req_o   (xfer_req_o),
    .xfer_done_i  (xfer_done_i),
    .promote_o    (promote),
    .irq_set_o    (irq_set),
    .idle_o       (idle_o)
  );

  assign xfer_desc_o  = {cur[LINK_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
  assign xfer_type_o  = cur[BIT_TYPE+1:BIT_TYPE];
  assign xfer_snoop_o = cur[BIT_SNOOP];

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (!mem_req_o && !xfer_req_o));
  assert_xfer_fields_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !xfer_done_i) |=>
      ($stable(xfer_desc_o) && $stable(xfer_type_o) && $stable(xfer_snoop_o)));
endmodule

// File: tb/test_dma_chain_seq.sv
module test_dma_chain_seq;
  localparam int LINK_OFS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        start_i = 1'b0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_gnt_i = 1'b0;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        xfer_req_o;
  logic [31:0] xfer_desc_o;
  logic [1:0]  xfer_type_o;
  logic        xfer_snoop_o;
  logic        xfer_done_i = 1'b0;
  logic        irq_o;
  logic        idle_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dma_chain_seq #(.LINK_OFS(LINK_OFS)) i_dma_chain_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .start_i(start_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .xfer_req_o(xfer_req_o), .xfer_desc_o(xfer_desc_o), .xfer_type_o(xfer_type_o),
    .xfer_snoop_o(xfer_snoop_o), .xfer_done_i(xfer_done_i),
    .irq_o(irq_o), .idle_o(idle_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    tick();
    reg_we_i = 1'b0;
  endtask

  function automatic logic [31:0] base_of(input int c, input int k);
    return 32'h0004_0000 + (32'(c) << 12) + (32'(k) << 7);
  endfunction

  function automatic logic [31:0] ctl_of(input int c, input int k);
    return 32'((c * 7 + k * 13) % 32) & 32'h1E;
  endfunction

  function automatic logic [31:0] link_of(input int c, input int k, input int n);
    if (k < n - 1) return base_of(c, k + 1) | ctl_of(c, k + 1);
    return ((32'hA5A5_A5A0 ^ (32'(c) << 5)) & ~32'h1F) | (32'((c * 3) % 16) << 1) | 32'h1;
  endfunction

  task automatic run(input int c, input bit chain, input bit setwin, input bit disturb);
    int n = chain ? (c % 4) + 1 : 1;
    int gd = c % 3;
    int rdl = (c + 1) % 3;
    int td = c % 2;
    logic [31:0] cur = base_of(c, 0) | 32'(c);
    logic [31:0] lk = '0;
    logic [31:0] d;
    bit irq_exp = 1'b0;
    wr(2'd0, {31'b0, chain});
    wr(2'd1, cur);
    rd(2'd1, d); chk("R10 cur write when idle", d, cur);
    start_i = 1'b1; tick(); start_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (chain) begin
        lk = link_of(c, k, n);
        chk("R2 fetch req", {31'b0, mem_req_o}, 32'd1);
        chk("R2 fetch addr", mem_addr_o, (cur & ~32'h1F) + LINK_OFS);
        for (int g = 0; g < gd; g++) begin
          tick(); chk("R2 req held", {31'b0, mem_req_o}, 32'd1);
          chk("R2 addr held", mem_addr_o, (cur & ~32'h1F) + LINK_OFS);
        end
        mem_gnt_i = 1'b1; tick(); mem_gnt_i = 1'b0;
        chk("R2 req drop", {31'b0, mem_req_o}, 32'd0);
        for (int r = 0; r < rdl; r++) begin
          tick(); chk("R3 wait data", {31'b0, xfer_req_o}, 32'd0);
        end
        mem_rvalid_i = 1'b1; mem_rdata_i = lk; tick();
        mem_rvalid_i = 1'b0; mem_rdata_i = 32'hFFFF_FFFF;
        rd(2'd2, d); chk("R3 next captured", d, lk);
      end else begin
        chk("R7 direct no fetch", {31'b0, mem_req_o}, 32'd0);
      end
      chk("R4 xfer req", {31'b0, xfer_req_o}, 32'd1);
      chk("R4 xfer desc", xfer_desc_o, cur & ~32'h1F);
      chk("R4 xfer type", {30'b0, xfer_type_o}, (cur >> 1) & 32'h3);
      chk("R4 xfer snoop", {31'b0, xfer_snoop_o}, (cur >> 4) & 32'h1);
      if (disturb && k == 0) begin
        wr(2'd1, 32'hDEAD_BEE0);
        wr(2'd0, {31'b0, ~chain});
        start_i = 1'b1; tick(); start_i = 1'b0;
        rd(2'd1, d); chk("R10 cur write ignored busy", d, cur);
        rd(2'd0, d); chk("R10 ctrl write ignored busy", d, {31'b0, chain});
        chk("R4 xfer still req", {31'b0, xfer_req_o}, 32'd1);
        chk("R4 desc stable", xfer_desc_o, cur & ~32'h1F);
      end
      for (int t = 0; t < td; t++) tick();
      xfer_done_i = 1'b1;
      if (setwin) begin reg_we_i = 1'b1; reg_addr_i = 2'd3; reg_wdata_i = 32'd1; end
      tick();
      xfer_done_i = 1'b0; reg_we_i = 1'b0;
      if (chain && cur[3]) irq_exp = 1'b1;
      chk(setwin ? "R9 set wins over clear" : "R8 irq after done", {31'b0, irq_o}, {31'b0, irq_exp});
      if (chain && !lk[0]) begin
        cur = lk;
        rd(2'd1, d); chk("R5 promote next to cur", d, cur);
        chk("R5 not idle", {31'b0, idle_o}, 32'd0);
      end else begin
        chk(chain ? "R6 stop idle" : "R7 direct idle", {31'b0, idle_o}, 32'd1);
        chk("R10 xfer off", {31'b0, xfer_req_o}, 32'd0);
        tick();
        chk("R10 idle", {31'b0, idle_o}, 32'd1);
        chk("R6 no refetch", {31'b0, mem_req_o}, 32'd0);
        rd(2'd1, d); chk("R6 cur kept", d, cur);
      end
    end
    if (irq_exp) begin
      wr(2'd3, 32'd1);
      chk("R9 irq cleared", {31'b0, irq_o}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); chk("R1 reg reset", d, 32'd0);
    end
    chk("R1 idle", {31'b0, idle_o}, 32'd1);
    chk("R1 irq", {31'b0, irq_o}, 32'd0);
    chk("R1 mem req", {31'b0, mem_req_o}, 32'd0);
    chk("R1 xfer req", {31'b0, xfer_req_o}, 32'd0);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R3 next write ignored", d, 32'd0);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R7 ctrl reads one bit", d, 32'd1);
    for (int c = 0; c < 32; c++) run(c, 1'b0, 1'b0, 1'b0);
    for (int c = 0; c < 32; c++) run(c, 1'b1, c == 8, c == 5);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule